// File: doc/BRIEF.md
# Halt Wake-Up and Reset Status Controller

This block manages the low-power halt state of a small microcontroller core. A halt command from the core stops the system clock enable and stalls the core. The block then waits for a wake-up source: an external or USB reset, a watchdog overflow, a new interrupt request, or a falling edge on an enabled port-A bit. Every reset and every wake-up is followed by a fixed start-up window. During that window the oscillator runs but the core is held stalled.

The block keeps two status flags, a time-out flag and a power-down flag. Software reads these flags to tell apart power-up, a reset while running, a reset out of halt, a watchdog time-out while running and a watchdog wake from halt. A cold-reset strobe tells the rest of the chip to return the program counter, interrupt enables, ports, timer and stack pointer to their initial state. A watchdog wake from halt gives a warm-reset strobe instead, which touches only the program counter and stack pointer. A port or interrupt wake-up ends with a one-cycle resume pulse. That pulse says whether the core should take the interrupt or carry on with the next instruction.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `por_n` is low, `flag_to` and `flag_pdf` are 0, `core_stall`, `osc_en` and `cold_rst` are 1. After release, `core_stall` stays high for exactly `DELAY_CYC` cycles and no resume pulse follows.
- R2: While running, `halt_req` with no reset or watchdog overflow in the same cycle halts the block: from the next cycle `osc_en` is 0 and `core_stall` is 1, with `flag_pdf`=1 and `flag_to`=0.
- R3: While running, `ext_rst` or `usb_rst` gives a one-cycle `cold_rst` pulse and a start-up window, and leaves both flags unchanged. It takes precedence over `wdt_ovf`, `halt_req` and `wdt_clr` in the same cycle.
- R4: While running, `wdt_ovf` with no reset gives a one-cycle `cold_rst` pulse and a start-up window. It sets `flag_to` to 1, leaves `flag_pdf` unchanged, and takes precedence over `halt_req`.
- R5: While running, `wdt_clr` with no other event clears `flag_pdf` and leaves `flag_to` unchanged.
- R6: In halt, `ext_rst` or `usb_rst` gives a `cold_rst` pulse and a start-up window, with `flag_to`=0 and `flag_pdf`=1.
- R7: In halt, `wdt_ovf` with no reset gives a one-cycle `warm_rst` pulse (no `cold_rst`) and a start-up window, with `flag_to`=1 and `flag_pdf`=1.
- R8: In halt, a 1-to-0 change on `porta_in[i]` while `porta_wake_en[i]`=1 wakes the block and ends with `resume_next`. A falling edge on a masked bit, or a rising edge on any bit, leaves `osc_en` at 0.
- R9: In halt, `irq_req` going high wakes the block. The values of `irq_en` and `stack_full` in the wake cycle select the resume pulse: `resume_irq` if `irq_en`=1 and `stack_full`=0, otherwise `resume_next`. These values are held internally until the pulse.
- R10: If `irq_req` is already 1 in the cycle `halt_req` is accepted, the interrupt cannot wake the block for the rest of that halt.
- R11: After any wake-up, `core_stall` stays high for exactly `DELAY_CYC` cycles. A resume pulse is one cycle long, falls in the first running cycle, and is never high together with another strobe.
- R12: In halt, reset outranks `wdt_ovf`, which outranks interrupt and port wake-ups. During the start-up window, `halt_req`, `wdt_ovf` and `wdt_clr` are ignored. `ext_rst` or `usb_rst` in the window pulses `cold_rst` and restarts a full `DELAY_CYC` window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| ext_rst | input | 1 | External reset request, one cycle |
| usb_rst | input | 1 | USB bus reset request, one cycle |
| wdt_ovf | input | 1 | Watchdog overflow |
| wdt_clr | input | 1 | Watchdog clear command from the core |
| halt_req | input | 1 | Halt command from the core |
| porta_in | input | PORT_W | Port-A pin levels |
| porta_wake_en | input | PORT_W | Per-bit wake-up enable for port A |
| irq_req | input | 1 | Pending interrupt request |
| irq_en | input | 1 | Enable of the requesting interrupt |
| stack_full | input | 1 | Return stack has no free entry |
| osc_en | output | 1 | System oscillator enable |
| core_stall | output | 1 | Holds the core from executing |
| cold_rst | output | 1 | Full reset strobe for the core and peripherals |
| warm_rst | output | 1 | Strobe resetting only program counter and stack pointer |
| resume_irq | output | 1 | Pulse: take the interrupt after wake-up |
| resume_next | output | 1 | Pulse: continue with the next instruction |
| flag_to | output | 1 | Time-out status flag |
| flag_pdf | output | 1 | Power-down status flag |

## Verification
The hardest case to reach is a halt in which stimulus that looks like a wake-up must be rejected. Examples are an interrupt request that was already pending at halt entry, a falling edge on a masked pin, and a rising edge on an enabled pin. Success in these cases shows only as the absence of a wake-up. The bench raises `irq_req` and lowers an enabled pin before issuing the halt, then moves the pins in halt and checks that `osc_en` stays low for several cycles. It then leaves halt through a reset, so the state kept in halt is also seen at the ports. Overlapping events are driven in single cycles to expose the priority order. Extra commands and a second reset are driven in the middle of a start-up window to show what is ignored and what restarts the window.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int PORT_W    = 8,
  parameter int DELAY_CYC = 1024
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst,
  input  logic              usb_rst,
  input  logic              wdt_ovf,
  input  logic              wdt_clr,
  input  logic              halt_req,
  input  logic [PORT_W-1:0] porta_in,
  input  logic [PORT_W-1:0] porta_wake_en,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic              stack_full,
  output logic              osc_en,
  output logic              core_stall,
  output logic              cold_rst,
  output logic              warm_rst,
  output logic              resume_irq,
  output logic              resume_next,
  output logic              flag_to,
  output logic              flag_pdf
);

  localparam int CNT_W = $clog2(DELAY_CYC + 1);

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_START} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [PORT_W-1:0] porta_q;
  logic              irq_block;
  logic              act_pend;
  logic              act_irq;

  wire in_run    = (st == ST_RUN);
  wire in_halt   = (st == ST_HALT);
  wire any_rst   = ext_rst | usb_rst;
  wire port_fall = |(porta_q & ~porta_in & porta_wake_en);
  wire irq_wake  = irq_req & ~irq_block;
  wire cnt_done  = (cnt == CNT_W'(DELAY_CYC - 1));

  assign osc_en     = ~in_halt;
  assign core_stall = ~in_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st          <= ST_START;
      cnt         <= '0;
      porta_q     <= '0;
      irq_block   <= 1'b0;
      act_pend    <= 1'b0;
      act_irq     <= 1'b0;
      flag_to     <= 1'b0;
      flag_pdf    <= 1'b0;
      cold_rst    <= 1'b1;
      warm_rst    <= 1'b0;
      resume_irq  <= 1'b0;
      resume_next <= 1'b0;
    end else begin
      porta_q     <= porta_in;
      cold_rst    <= 1'b0;
      warm_rst    <= 1'b0;
      resume_irq  <= 1'b0;
      resume_next <= 1'b0;
      case (st)
        ST_RUN: begin
          if (any_rst) begin
            st       <= ST_START;
            cnt      <= '0;
            cold_rst <= 1'b1;
            act_pend <= 1'b0;
          end else if (wdt_ovf) begin
            st       <= ST_START;
            cnt      <= '0;
            cold_rst <= 1'b1;
            act_pend <= 1'b0;
            flag_to  <= 1'b1;
          end else if (halt_req) begin
            st        <= ST_HALT;
            flag_pdf  <= 1'b1;
            flag_to   <= 1'b0;
            irq_block <= irq_req;
          end else if (wdt_clr) begin
            flag_pdf <= 1'b0;
          end
        end
        ST_HALT: begin
          if (any_rst) begin
            st       <= ST_START;
            cnt      <= '0;
            cold_rst <= 1'b1;
            act_pend <= 1'b0;
            flag_to  <= 1'b0;
            flag_pdf <= 1'b1;
          end else if (wdt_ovf) begin
            st       <= ST_START;
            cnt      <= '0;
            warm_rst <= 1'b1;
            act_pend <= 1'b0;
            flag_to  <= 1'b1;
            flag_pdf <= 1'b1;
          end else if (irq_wake) begin
            st       <= ST_START;
            cnt      <= '0;
            act_pend <= 1'b1;
            act_irq  <= irq_en & ~stack_full;
          end else if (port_fall) begin
            st       <= ST_START;
            cnt      <= '0;
            act_pend <= 1'b1;
            act_irq  <= 1'b0;
          end
        end
        ST_START: begin
          if (any_rst) begin
            cnt      <= '0;
            cold_rst <= 1'b1;
            act_pend <= 1'b0;
          end else if (cnt_done) begin
            st          <= ST_RUN;
            resume_irq  <= act_pend & act_irq;
            resume_next <= act_pend & ~act_irq;
            act_pend    <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_START;
      endcase
    end
  end

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && halt_req && !any_rst && !wdt_ovf) |=> (!osc_en && core_stall && flag_pdf && !flag_to));

  p_run_rst_keeps_flags_r3: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && any_rst) |=> (cold_rst && osc_en && $stable(flag_to) && $stable(flag_pdf)));

  p_wdt_run_r4: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && !any_rst && wdt_ovf) |=> (cold_rst && flag_to && $stable(flag_pdf)));

  p_clr_pdf_r5: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && !any_rst && !wdt_ovf && !halt_req && wdt_clr) |=> (!flag_pdf && $stable(flag_to)));

  p_halt_rst_flags_r6: assert property (@(posedge clk) disable iff (!por_n)
    (in_halt && any_rst) |=> (cold_rst && !flag_to && flag_pdf));

  p_warm_flags_r7: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |-> (flag_to && flag_pdf && core_stall && !cold_rst));

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    (in_halt && !any_rst && !wdt_ovf && !irq_wake && !port_fall) |=> !osc_en);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({resume_irq, resume_next, cold_rst, warm_rst}));

  p_resume_edge_r11: assert property (@(posedge clk) disable iff (!por_n)
    (resume_irq || resume_next) |-> (!core_stall && $past(core_stall)));

  p_start_ignores_r12: assert property (@(posedge clk) disable iff (!por_n)
    (!in_run && !in_halt && !any_rst) |=> ($stable(flag_to) && $stable(flag_pdf) && osc_en));

endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
  localparam int PW  = 8;
  localparam int DLY = 1024;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_rst = 0, usb_rst = 0, wdt_ovf = 0, wdt_clr = 0, halt_req = 0;
  logic [PW-1:0] porta_in = 8'hFF;
  logic [PW-1:0] porta_wake_en = 8'h05;
  logic irq_req = 0, irq_en = 0, stack_full = 0;
  logic osc_en, core_stall, cold_rst, warm_rst, resume_irq, resume_next, flag_to, flag_pdf;

  int n_chk = 0;
  int n_bad = 0;
  logic mto = 1'b0, mpdf = 1'b0;

  always #5 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PW), .DELAY_CYC(DLY)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .usb_rst(usb_rst), .wdt_ovf(wdt_ovf),
    .wdt_clr(wdt_clr), .halt_req(halt_req), .porta_in(porta_in), .porta_wake_en(porta_wake_en),
    .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full), .osc_en(osc_en),
    .core_stall(core_stall), .cold_rst(cold_rst), .warm_rst(warm_rst), .resume_irq(resume_irq),
    .resume_next(resume_next), .flag_to(flag_to), .flag_pdf(flag_pdf));

  // {pre_halt, ev[2:0], irq_en, stack_full, wakes, cold, warm, resume[1:0]}
  // ev: 0 ext, 1 usb, 2 wdt, 3 port bit0 fall, 4 irq, 5 wdt_clr; resume: 0 none, 1 next, 2 irq
  localparam logic [10:0] VEC [13] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    {1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    {1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
    {1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string req_of(input logic pre, input logic [2:0] ev);
    if (ev == 3'd3) return "R8";
    if (ev == 3'd4) return "R9";
    if (ev == 3'd5) return "R5";
    if (ev == 3'd2) return pre ? "R7" : "R4";
    return pre ? "R6" : "R3";
  endfunction

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // counts stall cycles from the current negedge, then checks the resume pulse
  task automatic wait_delay(input string tag, input int exp_res);
    int n = 0;
    while (core_stall && n < DLY + 10) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " R11 stall length"}, n, DLY);
    chk({tag, " R11 resume code"}, {resume_irq, resume_next}, exp_res);
    @(negedge clk);
    chk({tag, " R11 resume one cycle"}, {resume_irq, resume_next}, 0);
  endtask

  task automatic enter_halt(input string tag);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    mto = 1'b0; mpdf = 1'b1;
    chk({tag, " R2 osc_en"}, osc_en, 0);
    chk({tag, " R2 stall"}, core_stall, 1);
    chk({tag, " R2 flags"}, {flag_to, flag_pdf}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {flag_to, flag_pdf}, 0);
    chk("R1 reset stall/osc/cold", {core_stall, osc_en, cold_rst}, 3'b111);
    por_n = 1'b1;
    wait_delay("R1 power-up", 0);

    for (int i = 0; i < 13; i++) begin
      logic pre;
      logic [2:0] ev;
      string tg;
      pre = VEC[i][10];
      ev  = VEC[i][9:7];
      tg  = $sformatf("vec%0d %s", i, req_of(pre, ev));
      if (pre) enter_halt(tg);
      case (ev)
        3'd0: ext_rst = 1'b1;
        3'd1: usb_rst = 1'b1;
        3'd2: wdt_ovf = 1'b1;
        3'd3: porta_in[0] = 1'b0;
        3'd4: begin irq_req = 1'b1; irq_en = VEC[i][6]; stack_full = VEC[i][5]; end
        default: wdt_clr = 1'b1;
      endcase
      @(negedge clk);
      ext_rst = 0; usb_rst = 0; wdt_ovf = 0; wdt_clr = 0;
      irq_req = 0; irq_en = 0; stack_full = 0; porta_in = 8'hFF;
      if (ev == 3'd5) mpdf = 1'b0;
      else if (ev == 3'd2) begin mto = 1'b1; if (pre) mpdf = 1'b1; end
      else if (ev <= 3'd1 && pre) begin mto = 1'b0; mpdf = 1'b1; end
      chk({tg, " flags"}, {flag_to, flag_pdf}, {mto, mpdf});
      chk({tg, " cold/warm"}, {cold_rst, warm_rst}, VEC[i][3:2]);
      if (VEC[i][4]) wait_delay(tg, VEC[i][1:0]);
      else chk({tg, " still running"}, {core_stall, osc_en}, 2'b01);
    end

    // R8 / R10: masked fall, rising edge and a pending interrupt do not wake
    porta_in[2] = 1'b0;
    irq_req = 1'b1;
    @(negedge clk);
    enter_halt("R10 halt with pending irq");
    porta_in[1] = 1'b0;
    porta_in[2] = 1'b1;
    repeat (2) @(negedge clk);
    porta_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 masked fall / rising edge keep halt", osc_en, 0);
    chk("R10 pending irq cannot wake", {osc_en, core_stall}, 2'b01);
    irq_req = 1'b0;
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    mto = 1'b0; mpdf = 1'b1;
    chk("R6 exit from halt flags", {flag_to, flag_pdf}, {mto, mpdf});
    wait_delay("R6 exit", 0);

    // R3: reset beats halt in the same cycle
    ext_rst = 1'b1; halt_req = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0; halt_req = 1'b0;
    chk("R3 reset over halt cold/osc", {cold_rst, osc_en}, 2'b11);
    chk("R3 reset over halt flags", {flag_to, flag_pdf}, {mto, mpdf});
    wait_delay("R3 priority", 0);

    // R4: watchdog beats halt in the same cycle
    wdt_ovf = 1'b1; halt_req = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0; halt_req = 1'b0;
    mto = 1'b1;
    chk("R4 wdt over halt cold/osc", {cold_rst, osc_en}, 2'b11);
    chk("R4 wdt over halt flags", {flag_to, flag_pdf}, {mto, mpdf});
    wait_delay("R4 priority", 0);

    // R12: watchdog beats a port wake in halt
    enter_halt("R12 halt");
    wdt_ovf = 1'b1; porta_in[0] = 1'b0;
    @(negedge clk);
    wdt_ovf = 1'b0; porta_in = 8'hFF;
    mto = 1'b1; mpdf = 1'b1;
    chk("R12 wdt over port warm/cold", {warm_rst, cold_rst}, 2'b10);
    chk("R12 wdt over port flags", {flag_to, flag_pdf}, 2'b11);
    wait_delay("R12 wdt over port", 0);

    // R12: commands ignored in the start-up window, reset restarts it
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    repeat (10) @(negedge clk);
    halt_req = 1'b1; wdt_ovf = 1'b1; wdt_clr = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; wdt_ovf = 1'b0; wdt_clr = 1'b0;
    chk("R12 window ignores commands flags", {flag_to, flag_pdf}, {mto, mpdf});
    chk("R12 window ignores commands osc/cold", {osc_en, cold_rst}, 2'b10);
    repeat (50) @(negedge clk);
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    chk("R12 reset in window cold", cold_rst, 1);
    wait_delay("R12 restarted window", 0);
    chk("R12 flags after window", {flag_to, flag_pdf}, {mto, mpdf});

    finish_sim();
  end
endmodule